// File: doc/BRIEF.md
# Runtime-Selectable Square-Wave Clock Divider

This block derives a slower clock from a source clock, dividing it by an integer ratio between 1 and 8. The ratio comes from a small code input that may change at any time while the block runs. The output is a square wave with a 50% duty cycle for every ratio. For odd ratios this means a high time that is a whole number of source periods plus one half.

Inside, a rising-edge counter steps through one output period. A rising-edge waveform register is high for the first half of that count. For odd ratios, a second register copies that waveform on each falling source edge. Because it lags by half a source period, ORing the two stretches the high time to exactly half the output period. For a ratio of one, the source clock is passed straight through. A new code takes effect only at the rising edge that starts the next output period, so no shortened or stretched period is ever produced.

Top module: `var_clk_divider`

## Requirements
- R1: The code input `ratio_code` holds k, which requests division by k+1. Code 0 means divide by 1 and code 7 means divide by 8.
- R2: An internal count steps by one on each rising source edge, from 0 up to N-1, and then returns to 0. The output period is therefore N source periods.
- R3: For even N, the output is high for N/2 source periods and low for N/2 source periods. Each output period starts with a rising output edge coincident with a rising source edge.
- R4: For odd N of 3 or more, the output is high for exactly N/2 source periods, including the half period, and low for the same time. The falling output edge coincides with a falling source edge.
- R5: For N=1, the output follows the source clock: high for half a source period, with a period of one source period.
- R6: A change of code in the middle of an output period does not alter that period. The new ratio applies from the next period boundary.
- R7: While `rst_n` is low, the output is low and the counter is zero. Asserting reset in the middle of a period forces the output low at once.
- R8: After reset is released while the source clock is low, the first rising source edge starts a full output period at the ratio selected by the code present then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 3 | Requested ratio minus one |
| clk_out | output | 1 | Divided clock, 50% duty |

## Verification
The bench builds the block with its default maximum ratio of 8, so the 3-bit code spans every ratio from 1 to 8 and the clamp path stays idle. It sweeps all eight codes upward and then downward. This exercises every transition between odd, even and pass-through modes, including switching into and out of pass-through. It measures the high time and the period of the output against the source period. It also changes the code partway through a divide-by-8 period, releases reset at a known phase, and asserts reset while the output is high.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // How the output is formed for the ratio currently in force
  typedef enum logic [1:0] {
    OUT_BYPASS = 2'd0,  // ratio 1: source clock straight through
    OUT_EVEN   = 2'd1,  // rising-edge waveform alone
    OUT_ODD    = 2'd2   // rising-edge waveform ORed with falling-edge copy
  } out_mode_e;

  function automatic out_mode_e mode_for(input int unsigned ratio);
    if (ratio <= 1)          return OUT_BYPASS;
    else if (ratio % 2 == 1) return OUT_ODD;
    else                     return OUT_EVEN;
  endfunction

endpackage

// File: rtl/clkdiv_period_ctr.sv
`timescale 1ns/1ps
// Period counter and ratio register; a new ratio is taken only at the wrap.
module clkdiv_period_ctr #(
  parameter  int MAX_RATIO = 8,
  localparam int SEL_W = $clog2(MAX_RATIO),
  localparam int CNT_W = $clog2(MAX_RATIO),
  localparam int RAT_W = $clog2(MAX_RATIO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_code,
  output logic [CNT_W-1:0] cnt_q,
  output logic [RAT_W-1:0] ratio_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [RAT_W-1:0] ratio_nxt
);

  localparam logic [RAT_W-1:0] MAX_R = RAT_W'(MAX_RATIO);

  logic [RAT_W-1:0] req_raw;
  logic [RAT_W-1:0] req_ratio;
  logic             wrap;

  assign req_raw = RAT_W'(ratio_code) + RAT_W'(1);

  // Codes beyond the largest ratio exist only if the code space is wider
  generate
    if ((1 << SEL_W) > MAX_RATIO) begin : g_clamp
      assign req_ratio = (req_raw > MAX_R) ? MAX_R : req_raw;
    end else begin : g_direct
      assign req_ratio = req_raw;
    end
  endgenerate

  assign wrap      = (RAT_W'(cnt_q) + RAT_W'(1)) == ratio_q;
  assign cnt_nxt   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign ratio_nxt = wrap ? req_ratio : ratio_q;

  // Reset ratio is 1, so the first rising edge is a wrap and loads the code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(1);
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
    end
  end

endmodule

// File: rtl/clkdiv_rise_wave.sv
`timescale 1ns/1ps
// Rising-edge waveform: high while the count sits in the first floor(N/2) slots.
module clkdiv_rise_wave #(
  parameter  int MAX_RATIO = 8,
  localparam int CNT_W = $clog2(MAX_RATIO),
  localparam int RAT_W = $clog2(MAX_RATIO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [RAT_W-1:0] ratio_nxt,
  output logic             wave_q
);

  logic [RAT_W-1:0] half_n;
  logic             wave_d;

  assign half_n = ratio_nxt >> 1;
  assign wave_d = RAT_W'(cnt_nxt) < half_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/clkdiv_fall_stage.sv
`timescale 1ns/1ps
// Half-period retime of the rising-edge waveform on the falling source edge.
module clkdiv_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/var_clk_divider.sv
`timescale 1ns/1ps
module var_clk_divider #(
  parameter  int MAX_RATIO = 8,
  localparam int SEL_W = $clog2(MAX_RATIO),
  localparam int CNT_W = $clog2(MAX_RATIO),
  localparam int RAT_W = $clog2(MAX_RATIO + 1)
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_code,
  output logic             clk_out
);
  import clkdiv_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [RAT_W-1:0] ratio_nxt;
  logic             rise_q;
  logic             fall_q;
  out_mode_e        mode;

  clkdiv_period_ctr #(.MAX_RATIO(MAX_RATIO)) ctr_i (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .cnt_q      (cnt_q),
    .ratio_q    (ratio_q),
    .cnt_nxt    (cnt_nxt),
    .ratio_nxt  (ratio_nxt)
  );

  clkdiv_rise_wave #(.MAX_RATIO(MAX_RATIO)) rise_i (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .cnt_nxt   (cnt_nxt),
    .ratio_nxt (ratio_nxt),
    .wave_q    (rise_q)
  );

  clkdiv_fall_stage fall_i (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d     (rise_q),
    .q     (fall_q)
  );

  assign mode = mode_for(int'(ratio_q));

  always_comb begin
    unique case (mode)
      OUT_BYPASS: clk_out = clk_src & rst_n;
      OUT_ODD:    clk_out = rise_q | fall_q;
      default:    clk_out = rise_q;
    endcase
  end

endmodule

// File: rtl/clkdiv_sva.sv
`timescale 1ns/1ps
module clkdiv_sva #(
  parameter  int MAX_RATIO = 8,
  localparam int SEL_W = $clog2(MAX_RATIO),
  localparam int CNT_W = $clog2(MAX_RATIO),
  localparam int RAT_W = $clog2(MAX_RATIO + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] ratio_code,
  input logic [CNT_W-1:0] cnt,
  input logic [RAT_W-1:0] ratio,
  input logic             rise
);

  localparam logic [RAT_W-1:0] MAX_R = RAT_W'(MAX_RATIO);

  logic             at_end;
  logic [RAT_W-1:0] want_ratio;

  assign at_end     = (RAT_W'(cnt) + RAT_W'(1)) == ratio;
  assign want_ratio = ((RAT_W'(ratio_code) + RAT_W'(1)) > MAX_R) ? MAX_R
                      : RAT_W'(ratio_code) + RAT_W'(1);

  assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RAT_W'(1)) && (ratio <= MAX_R));

  assert_ratio_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> ratio == $past(want_ratio));

  assert_cnt_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    RAT_W'(cnt) < ratio);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> cnt == $past(cnt) + CNT_W'(1));

  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> cnt == '0);

  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(ratio));

  assert_first_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RAT_W'(2)) |-> (rise == (RAT_W'(cnt) < (ratio >> 1))));

endmodule

bind var_clk_divider clkdiv_sva #(.MAX_RATIO(MAX_RATIO)) sva_i (
  .clk        (clk_src),
  .rst_n      (rst_n),
  .ratio_code (ratio_code),
  .cnt        (cnt_q),
  .ratio      (ratio_q),
  .rise       (rise_q)
);

// File: tb/var_clk_divider_tb_top.sv
`timescale 1ns/1ps
module var_clk_divider_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic       clk_src    = 1'b0;
  logic       rst_n      = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  wire        clk_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  var_clk_divider dut_i (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .clk_out    (clk_out)
  );

  always #(HALF) clk_src = ~clk_src;

  task automatic check_val(input string req, input string what,
                           input longint actual, input longint expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // High time and period of one complete output period
  task automatic measure(output longint hi, output longint per);
    longint t0, t1, t2;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  // Change the code away from the clock edges and wait for the boundary
  task automatic apply_code(input int k);
    @(negedge clk_src);
    ratio_code = 3'(k);
    @(posedge clk_out);
  endtask

  task automatic test_reset_state();
    ratio_code = 3'd3;
    for (int i = 0; i < 6; i++) begin
      #(HALF / 2 + 1);
      check_val("R7", "output during reset", longint'(clk_out), 0);
    end
  endtask

  task automatic test_first_period();
    longint t_rel, t_r, t_f;
    @(negedge clk_src);
    #1;
    t_rel = $time;
    rst_n = 1'b1;
    @(posedge clk_out); t_r = $time;
    @(negedge clk_out); t_f = $time;
    check_val("R8", "first rise delay after release", t_r - t_rel, HALF - 1);
    check_val("R8", "first high time at ratio 4", t_f - t_r, 4 * HALF);
  endtask

  task automatic sweep_one(input int k);
    longint hi, per;
    string  tag;
    apply_code(k);
    measure(hi, per);
    if (k == 0)          tag = "R1 R5";
    else if (k % 2 == 1) tag = "R1 R2 R3";
    else                 tag = "R1 R2 R4";
    check_val(tag, $sformatf("high time ratio %0d", k + 1), hi, longint'((k + 1) * HALF));
    check_val(tag, $sformatf("period ratio %0d", k + 1), per, longint'((k + 1) * CLK_PERIOD));
  endtask

  task automatic test_sweep();
    for (int k = 0; k < 8; k++) sweep_one(k);
    for (int k = 7; k >= 0; k--) sweep_one(k);
  endtask

  task automatic test_mid_switch();
    longint t0, t1, t2, t3, t4;
    apply_code(7);
    t0 = $time;
    repeat (3) @(negedge clk_src);
    ratio_code = 3'd2;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    @(negedge clk_out); t3 = $time;
    @(posedge clk_out); t4 = $time;
    check_val("R6", "old-ratio high time kept", t1 - t0, 8 * HALF);
    check_val("R6", "old-ratio period kept", t2 - t0, 8 * CLK_PERIOD);
    check_val("R6", "new-ratio high time", t3 - t2, 3 * HALF);
    check_val("R6", "new-ratio period", t4 - t2, 3 * CLK_PERIOD);
  endtask

  task automatic test_reset_midrun();
    apply_code(5);
    #3;
    check_val("R7", "output high before reset", longint'(clk_out), 1);
    rst_n = 1'b0;
    #1;
    check_val("R7", "output after mid-run reset", longint'(clk_out), 0);
    repeat (3) @(posedge clk_src);
    #1;
    check_val("R7", "output held low in reset", longint'(clk_out), 0);
  endtask

  initial begin
    test_reset_state();
    test_first_period();
    test_sweep();
    test_mid_switch();
    test_reset_midrun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_src);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule